// File: doc/BRIEF.md
# Key-Gated Register Fault Injector

This block guards a small bank of five configuration registers, each stored with single-error-correct, double-error-detect (SECDED) check bits. It also gives software a controlled way to corrupt that storage, so the error-handling path can be tested on silicon. A control register accepts fault-injection commands only when a 24-bit key is written with them. Each command can flip one or two stored check bits in any chosen set of the five register groups. Every accepted injection raises sticky error flags, and these flags are cleared by reading the status word.

A one-way disable bit turns the injection feature off until the next hardware reset. The block accepts the disable only when no data-error or non-correctable flag is pending and the same write selects no group. Reads of a protected register return its corrected data, together with two decoder indications: a correctable error was seen, or an uncorrectable error was seen. A normal write to a protected register stores fresh check bits.

The bus is a simple single-cycle word interface. Writes take effect on the clock edge. Read data is combinational while the read strobe is high, and a status read clears the flags on that clock edge.

Top module: `keyed_fault_injector`

## Requirements
- R1: After reset, the control word, the status word and all five group words read back as 0.
- R2: A control write (word address 0) whose bits 31:8 differ from 0x534649 has no effect at all. No flag is set and the disable bit is unchanged.
- R3: A read of the control word returns 0 in bits 31:8 and bits 6:0. Bit 7 shows the disable state.
- R4: Bits 4:0 of a keyed control write select groups 0 to 4. Group i sits at word address 2+i. When any selected bit is 1, the status bit 0 (single-error) and bit 1 (data-error) are set.
- R5: Status bit 2 (non-correctable) is set by injection into groups 1, 2 or 3 in either fault mode. For groups 0 and 4 it is set only when bit 5 of the write is 1 (double fault).
- R6: Injection touches only check bits. Stored bit 0 is flipped for a single fault, and bits 0 and 1 for a double fault. A later group read returns the written data in bits 15:0, with bit 30 set after a single fault and bit 31 set after a double fault.
- R7: A keyed write with bit 7 = 1, bits 4:0 = 0 and status bits 1 and 2 clear sets the disable bit. The bit stays 1 until reset. Writing bit 7 = 0 never clears it.
- R8: The disable request is refused while the data-error or non-correctable flag is set, or when the same write selects any group. A write that selects groups still injects.
- R9: While disabled, keyed writes that select groups change neither the flags nor the group storage.
- R10: The status flags remain set until the status word (word address 1) is read. That read returns them and clears all three.
- R11: A write to a group stores the data with fresh check bits. A read afterwards returns the data with bits 30 and 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one word per cycle |
| rdEn | input | 1 | Read strobe |
| addr | input | 3 | Word address: 0 control, 1 status, 2..6 groups 0..4 |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, zero when rdEn is low |

## Verification
The properties assume that the bus never raises the read and write strobes in the same cycle. Under that assumption a flag change can have only one cause per edge: an injection sets flags, and a status read clears them. They also assume that reset is applied from time zero. The directed bench drives every access through one write task or one read task. Each access is a single strobe, set at a falling edge and dropped one cycle later, so the two strobes never overlap.

// File: rtl/kfi_pkg.sv
package kfi_pkg;
  localparam int NUM_GRP = 5;
  localparam int ADDR_W = 3;
  localparam logic [23:0] UNLOCK_KEY = 24'h534649;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam int GRP_BASE = 2;
  // groups whose injection is always non-correctable
  localparam logic [NUM_GRP-1:0] NC_ALWAYS = 5'b01110;

  typedef struct packed {
    logic [NUM_GRP-1:0] grpWr;
    logic [NUM_GRP-1:0] rdGrp;
    logic [NUM_GRP-1:0] inject;
    logic               dbl;
  } kfi_strobe_t;
endpackage

// File: rtl/kfi_ctrl.sv
module kfi_ctrl
  import kfi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output kfi_strobe_t       strobe,
  output logic              singleErr,
  output logic              dataErr,
  output logic              nonCorr,
  output logic              fiOff
);
  logic ctrlWr, keyOk, keyedWr, injGo, disGo, statRd, ncHit;
  logic [NUM_GRP-1:0] fSel;
  logic dblMode, disReq;
  logic unusedBit;

  assign unusedBit = wrData[6];
  assign ctrlWr  = wrEn && (addr == A_CTRL);
  assign keyOk   = (wrData[31:8] == UNLOCK_KEY);
  assign keyedWr = ctrlWr && keyOk;
  assign fSel    = wrData[NUM_GRP-1:0];
  assign dblMode = wrData[5];
  assign disReq  = wrData[7];
  assign statRd  = rdEn && (addr == A_STAT);

  assign injGo = keyedWr && !fiOff && (|fSel);
  assign disGo = keyedWr && disReq && (fSel == '0) && !dataErr && !nonCorr;
  assign ncHit = (|(fSel & NC_ALWAYS)) || (dblMode && (|(fSel & ~NC_ALWAYS)));

  always_comb begin
    strobe.inject = injGo ? fSel : '0;
    strobe.dbl    = dblMode;
    for (int i = 0; i < NUM_GRP; i++) begin
      strobe.grpWr[i] = wrEn && (addr == ADDR_W'(GRP_BASE + i));
      strobe.rdGrp[i] = (addr == ADDR_W'(GRP_BASE + i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleErr <= 1'b0;
      dataErr   <= 1'b0;
      nonCorr   <= 1'b0;
    end else if (injGo) begin
      singleErr <= 1'b1;
      dataErr   <= 1'b1;
      nonCorr   <= nonCorr | ncHit;
    end else if (statRd) begin
      singleErr <= 1'b0;
      dataErr   <= 1'b0;
      nonCorr   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      fiOff <= 1'b0;
    else if (disGo) fiOff <= 1'b1;
  end
endmodule

// File: rtl/kfi_datapath.sv
module kfi_datapath
  import kfi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  kfi_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrWord,
  output logic [31:0]       grpWord
);
  function automatic int calcPar(int dw);
    int p;
    p = 1;
    for (int i = 0; i < 32; i++)
      if ((1 << p) < dw + p + 1) p = p + 1;
    return p;
  endfunction

  localparam int PAR_W = calcPar(DATA_W);
  localparam int POS_N = DATA_W + PAR_W;
  localparam int CW_W  = POS_N + 1;

  function automatic logic [CW_W-1:0] encode(logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    int j;
    cw = '0;
    j = 0;
    for (int pos = 1; pos <= POS_N; pos++)
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = d[j];
        j++;
      end
    for (int p = 0; p < PAR_W; p++) begin
      logic b;
      b = 1'b0;
      for (int pos = 1; pos <= POS_N; pos++)
        if (((pos >> p) & 1) == 1) b = b ^ cw[pos];
      cw[1 << p] = b;
    end
    cw[0] = ^cw[POS_N:1];
    return cw;
  endfunction

  // returns {uncorrectable, corrected, data}
  function automatic logic [DATA_W+1:0] decode(logic [CW_W-1:0] cwIn);
    logic [CW_W-1:0] cw;
    logic [PAR_W-1:0] syn;
    logic [DATA_W-1:0] d;
    logic corr, uncorr;
    int j;
    cw = cwIn;
    corr = 1'b0;
    uncorr = 1'b0;
    for (int p = 0; p < PAR_W; p++) begin
      logic b;
      b = 1'b0;
      for (int pos = 1; pos <= POS_N; pos++)
        if (((pos >> p) & 1) == 1) b = b ^ cw[pos];
      syn[p] = b;
    end
    if (^cw) begin
      corr = 1'b1;
      if ((syn != '0) && (int'(syn) <= POS_N)) cw[syn] = ~cw[syn];
    end else if (syn != '0) begin
      uncorr = 1'b1;
    end
    d = '0;
    j = 0;
    for (int pos = 1; pos <= POS_N; pos++)
      if ((pos & (pos - 1)) != 0) begin
        d[j] = cw[pos];
        j++;
      end
    return {uncorr, corr, d};
  endfunction

  logic [CW_W-1:0] store [NUM_GRP];
  logic [DATA_W+1:0] dec [NUM_GRP];
  logic [CW_W-1:0] flipMask;

  assign flipMask = strobe.dbl ? CW_W'(3) : CW_W'(1);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  store[g] <= '0;
      else if (strobe.grpWr[g])   store[g] <= encode(wrWord);
      else if (strobe.inject[g])  store[g] <= store[g] ^ flipMask;
    end
    assign dec[g] = decode(store[g]);
  end

  always_comb begin
    logic [DATA_W+1:0] sel;
    sel = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (strobe.rdGrp[g]) sel = sel | dec[g];
    grpWord = '0;
    grpWord[DATA_W-1:0] = sel[DATA_W-1:0];
    grpWord[30] = sel[DATA_W];
    grpWord[31] = sel[DATA_W+1];
  end
endmodule

// File: rtl/keyed_fault_injector.sv
module keyed_fault_injector
  import kfi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData
);
  kfi_strobe_t strobe;
  logic singleErr, dataErr, nonCorr, fiOff;
  logic [31:0] grpWord;

  kfi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strobe(strobe), .singleErr(singleErr),
    .dataErr(dataErr), .nonCorr(nonCorr), .fiOff(fiOff)
  );

  kfi_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrWord(wrData[DATA_W-1:0]), .grpWord(grpWord)
  );

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == A_CTRL)      rdData = {24'h0, fiOff, 7'h0};
      else if (addr == A_STAT) rdData = {29'h0, nonCorr, dataErr, singleErr};
      else                     rdData = grpWord;
    end
  end
endmodule

// File: rtl/kfi_checker.sv
module kfi_checker
  import kfi_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              singleErr,
  input logic              dataErr,
  input logic              nonCorr,
  input logic              fiOff
);
  p_bus_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn));

  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_CTRL && wrData[31:8] != UNLOCK_KEY)
    |=> $stable({singleErr, dataErr, nonCorr, fiOff}));

  p_inject_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_CTRL && wrData[31:8] == UNLOCK_KEY && !fiOff && wrData[4:0] != 5'b0)
    |=> (singleErr && dataErr));

  p_nc_needs_de_r5: assert property (@(posedge clk) disable iff (!rstN)
    nonCorr |-> dataErr);

  p_off_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    fiOff |=> fiOff);

  p_off_guard_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fiOff) |-> (!$past(dataErr) && !$past(nonCorr)));

  p_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fiOff && wrEn && addr == A_CTRL)
    |=> $stable({singleErr, dataErr, nonCorr}));

  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_STAT) |=> (!singleErr && !dataErr && !nonCorr));
endmodule

bind keyed_fault_injector kfi_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .singleErr(singleErr), .dataErr(dataErr),
  .nonCorr(nonCorr), .fiOff(fiOff)
);

// File: tb/test_keyed_fault_injector.sv
module test_keyed_fault_injector;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] KEY = 24'h534649;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  int nChecks = 0;
  int nFails = 0;

  keyed_fault_injector i_keyed_fault_injector (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] ctrlWord(logic [23:0] k, logic dis, logic dbl, logic [4:0] f);
    return {k, dis, 1'b0, dbl, f};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    busRd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    busRd(3'd1, v); chk("R1 status", v, 32'h0);
    for (int g = 0; g < 5; g++) begin
      busRd(3'(2 + g), v); chk("R1 group", v, 32'h0);
    end
  endtask

  task automatic t_bad_key();
    logic [31:0] v;
    busWr(3'd2, 32'h0000_1234);
    busWr(3'd0, ctrlWord(24'h534648, 1'b0, 1'b1, 5'b11111));
    busRd(3'd1, v); chk("R2 no flags", v, 32'h0);
    busRd(3'd2, v); chk("R2 group intact", v, 32'h0000_1234);
    busWr(3'd0, ctrlWord(24'h000000, 1'b1, 1'b0, 5'b0));
    busRd(3'd0, v); chk("R2 no disable", v, 32'h0);
  endtask

  task automatic t_inject(int g, logic dbl);
    logic [31:0] v, d;
    logic nc;
    d = 32'(16'hA5C3 ^ (g * 16'h1111));
    busWr(3'(2 + g), d);
    busRd(3'(2 + g), v); chk("R11 clean write", v, d);
    busWr(3'd0, ctrlWord(KEY, 1'b0, dbl, 5'(1 << g)));
    nc = (g >= 1 && g <= 3) || dbl;
    busRd(3'd1, v); chk(nc ? "R5 flags nc" : "R4 flags", v, {29'h0, nc, 2'b11});
    busRd(3'd1, v); chk("R10 cleared", v, 32'h0);
    busRd(3'(2 + g), v);
    chk("R6 data kept", v, d | (dbl ? 32'h8000_0000 : 32'h4000_0000));
    busWr(3'(2 + g), d);
    busRd(3'(2 + g), v); chk("R11 rewrite clean", v, d);
  endtask

  task automatic t_sticky_multi();
    logic [31:0] v;
    busWr(3'd0, ctrlWord(KEY, 1'b0, 1'b0, 5'b10001));
    repeat (3) @(negedge clk);
    busRd(3'd0, v); chk("R3 ctrl readback", v, 32'h0);
    busRd(3'd1, v); chk("R10 sticky", v, 32'h3);
    busRd(3'd2, v); chk("R4 group0 hit", v, 32'h4000_0000 | 32'(16'hA5C3));
    busRd(3'd6, v); chk("R4 group4 hit", v, 32'h4000_0000 | 32'(16'hA5C3 ^ 16'h4444));
    busRd(3'd4, v); chk("R4 group2 untouched", v, 32'(16'hA5C3 ^ 16'h2222));
    busWr(3'd2, 32'(16'hA5C3));
    busWr(3'd6, 32'(16'hA5C3 ^ 16'h4444));
  endtask

  task automatic t_disable();
    logic [31:0] v;
    busWr(3'd0, ctrlWord(KEY, 1'b0, 1'b1, 5'b00001));
    busWr(3'd0, ctrlWord(KEY, 1'b1, 1'b0, 5'b0));
    busRd(3'd0, v); chk("R8 refused flags pending", v, 32'h0);
    busRd(3'd1, v); chk("R8 flags", v, 32'h7);
    busWr(3'd2, 32'(16'hA5C3));
    busWr(3'd0, ctrlWord(KEY, 1'b1, 1'b0, 5'b00100));
    busRd(3'd0, v); chk("R8 refused fsel", v, 32'h0);
    busRd(3'd1, v); chk("R8 still injects", v, 32'h7);
    busWr(3'd4, 32'(16'hA5C3 ^ 16'h2222));
    busWr(3'd0, ctrlWord(KEY, 1'b1, 1'b0, 5'b0));
    busRd(3'd0, v); chk("R7 disabled", v, 32'h80);
    busWr(3'd0, ctrlWord(KEY, 1'b0, 1'b1, 5'b11111));
    busRd(3'd1, v); chk("R9 no flags", v, 32'h0);
    busRd(3'd3, v); chk("R9 storage clean", v, 32'(16'hA5C3 ^ 16'h1111));
    busWr(3'd0, ctrlWord(KEY, 1'b0, 1'b0, 5'b0));
    busRd(3'd0, v); chk("R7 write 0 no effect", v, 32'h80);
    doReset();
    busRd(3'd0, v); chk("R7 reset clears", v, 32'h0);
    busWr(3'd0, ctrlWord(KEY, 1'b0, 1'b0, 5'b00010));
    busRd(3'd1, v); chk("R4 after reset", v, 32'h7);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_bad_key();
    for (int g = 0; g < 5; g++) begin
      t_inject(g, 1'b0);
      t_inject(g, 1'b1);
    end
    t_sticky_multi();
    t_disable();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule